// File: doc/BRIEF.md
# Tagged-Token Matching Processing Element

This block is one execution node of a dataflow fabric. It holds up to eight resident instructions. Each instruction has its own operand queues, one per input. Tokens arrive one per cycle on the operand port. Each token names the target slot, the input port and the wave tag. An instruction fires only when every input it uses holds a token with the instruction's current wave. When it fires, those entries are consumed. The result then leaves as one or two tagged tokens, each addressed to a consumer {slot, input port}.

Three operations are supported. The first sums its inputs. The second is a conditional steer: it sends input 0 toward one of two destinations, chosen by input 1. The third is a wave advance: it passes input 0 through with its wave tag raised by one. Queue entries are located by wave number relative to the instruction's current wave. The window is four waves deep. A token that lands on an occupied entry, or falls outside the window, is held off with ready low.

A configuration write loads one slot and resets that slot's state. It sets the opcode, an input count and two optional destinations. It also clears the slot's queues and resets its current wave to 0.

Top module: `pe_token_engine`

## Requirements
- R1: After reset `outValid` is 0 and every slot is unconfigured, so `inReady` is 0 for every token.
- R2: A token is accepted (`inReady` 1) only if its slot is configured and its port is below the slot's input count (1 to 3). Its wave minus the slot's current wave must be 0 to 3. The addressed queue entry must be empty. A port at or above the input count is refused.
- R3: A slot fires only when each used input holds a token of its current wave. Tokens of different waves are never combined. Each firing advances the slot's current wave by one, so waves fire in order.
- R4: Opcode 0 (add) emits the modulo-2^16 sum of the used inputs, tagged with the fired wave. The token appears on the output in the second cycle after the last operand is accepted.
- R5: Opcode 1 (steer) emits input 0 to destination 0 when input 1 is zero, and to destination 1 otherwise. It emits exactly one token; the other path gets none.
- R6: Opcode 2 (wave advance) emits input 0 unchanged, tagged with the fired wave plus one.
- R7: A non-steer slot with both destinations enabled emits two tokens in consecutive cycles, destination 0 first. No slot fires in the cycle of the second token.
- R8: When several slots are ready in the same cycle, the lowest slot index fires first. The others fire in later cycles.
- R9: `inReady` is 0 for a token whose entry is occupied, or whose wave is ahead of or behind the window. Once the slot fires, the window slides and a token one wave further ahead is accepted.
- R10: Reconfiguring a slot discards its queued tokens and sets its current wave to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration write strobe |
| cfgSlot | input | 3 | Slot to load |
| cfgOp | input | 2 | Opcode: 0 add, 1 steer, 2 wave advance |
| cfgNumIn | input | 2 | Number of used inputs, 1 to 3 |
| cfgDstValid | input | 2 | Enable bits for destination 1 and destination 0 |
| cfgDst0Slot | input | 3 | Destination 0 consumer slot |
| cfgDst0Port | input | 2 | Destination 0 consumer input port |
| cfgDst1Slot | input | 3 | Destination 1 consumer slot |
| cfgDst1Port | input | 2 | Destination 1 consumer input port |
| inValid | input | 1 | Operand token present |
| inReady | output | 1 | Operand token can be accepted this cycle |
| inSlot | input | 3 | Target instruction slot |
| inPort | input | 2 | Target input port |
| inWave | input | 8 | Token wave tag |
| inData | input | 16 | Token value |
| outValid | output | 1 | Result token present (one cycle) |
| outSlot | output | 3 | Consumer slot of the result |
| outPort | output | 2 | Consumer input port of the result |
| outWave | output | 8 | Wave tag of the result |
| outData | output | 16 | Result value |

## Verification
The bench first feeds operands of two different waves to one instruction. A design that matched by arrival order rather than by tag would emit a sum mixing waves. It then pushes tokens onto an occupied entry, and past both edges of the wave window. A design without correct backpressure would overwrite a pending operand, or accept a wave it cannot place. The bench also makes a two-destination firing overlap with two other slots becoming ready. Wrong priority or serialization would show up as tokens out of order or arriving a cycle early. Finally, it reconfigures a slot that still holds stale operands. A design that kept them would fire with the old data.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [1:0] {
    OP_ADD     = 2'd0,
    OP_STEER   = 2'd1,
    OP_WAVEADV = 2'd2
  } pe_opcode_e;

  // strobes from the firing control to the operand datapath
  typedef struct packed {
    logic acceptTok;   // write the presented token into its queue entry
    logic fire;        // consume the chosen slot's current wave and launch
    logic sendSecond;  // launch the held second destination
  } pe_strobe_t;

endpackage

// File: rtl/pe_token_store.sv
module pe_token_store
  import pe_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int MAX_IN    = 3,
  parameter int QDEPTH    = 4,
  parameter int DATA_W    = 16,
  parameter int WAVE_W    = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int PORT_W   = $clog2(MAX_IN),
  localparam int CNT_W    = $clog2(MAX_IN + 1),
  localparam int QIDX_W   = $clog2(QDEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic [1:0]           cfgOp,
  input  logic [CNT_W-1:0]     cfgNumIn,
  input  logic [1:0]           cfgDstValid,
  input  logic [SLOT_W-1:0]    cfgDst0Slot,
  input  logic [PORT_W-1:0]    cfgDst0Port,
  input  logic [SLOT_W-1:0]    cfgDst1Slot,
  input  logic [PORT_W-1:0]    cfgDst1Port,
  input  logic [SLOT_W-1:0]    inSlot,
  input  logic [PORT_W-1:0]    inPort,
  input  logic [WAVE_W-1:0]    inWave,
  input  logic [DATA_W-1:0]    inData,
  input  pe_strobe_t           strobe,
  input  logic [SLOT_W-1:0]    fireSlot,
  output logic                 tokFree,
  output logic [NUM_SLOTS-1:0] readyVec,
  output logic                 fireNeedsTwo,
  output logic                 outValid,
  output logic [SLOT_W-1:0]    outSlot,
  output logic [PORT_W-1:0]    outPort,
  output logic [WAVE_W-1:0]    outWave,
  output logic [DATA_W-1:0]    outData
);

  // per-slot instruction state
  logic                cfgd      [NUM_SLOTS];
  pe_opcode_e          opR       [NUM_SLOTS];
  logic [CNT_W-1:0]    numInR    [NUM_SLOTS];
  logic [1:0]          dstValR   [NUM_SLOTS];
  logic [SLOT_W-1:0]   dst0SlotR [NUM_SLOTS];
  logic [PORT_W-1:0]   dst0PortR [NUM_SLOTS];
  logic [SLOT_W-1:0]   dst1SlotR [NUM_SLOTS];
  logic [PORT_W-1:0]   dst1PortR [NUM_SLOTS];
  logic [WAVE_W-1:0]   baseWave  [NUM_SLOTS];

  // operand queues, entry chosen by wave modulo depth
  logic                qValid [NUM_SLOTS][MAX_IN][QDEPTH];
  logic [DATA_W-1:0]   qData  [NUM_SLOTS][MAX_IN][QDEPTH];

  // held second destination
  logic [SLOT_W-1:0]   holdSlot;
  logic [PORT_W-1:0]   holdPort;

  // ---------------- token admission ----------------
  logic [QIDX_W-1:0] inIdx;
  logic [WAVE_W-1:0] inRel;
  assign inIdx = inWave[QIDX_W-1:0];
  assign inRel = inWave - baseWave[inSlot];

  always_comb begin
    tokFree = cfgd[inSlot]
           && (CNT_W'(inPort) < numInR[inSlot])
           && (inRel < WAVE_W'(QDEPTH));
    if (tokFree) tokFree = !qValid[inSlot][inPort][inIdx];
  end

  // ---------------- readiness per slot ----------------
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ready
    logic [QIDX_W-1:0] baseIdx;
    assign baseIdx = baseWave[s][QIDX_W-1:0];
    always_comb begin
      readyVec[s] = cfgd[s];
      for (int p = 0; p < MAX_IN; p++) begin
        if (CNT_W'(p) < numInR[s]) readyVec[s] = readyVec[s] & qValid[s][p][baseIdx];
      end
    end
  end

  // ---------------- function unit ----------------
  logic [QIDX_W-1:0] fireIdx;
  logic [DATA_W-1:0] opnd [MAX_IN];
  logic [DATA_W-1:0] sum, resData;
  logic [WAVE_W-1:0] resWave;
  logic [1:0]        sendMask;
  logic              selTrue;

  assign fireIdx = baseWave[fireSlot][QIDX_W-1:0];

  always_comb begin
    sum = '0;
    for (int p = 0; p < MAX_IN; p++) begin
      opnd[p] = qData[fireSlot][p][fireIdx];
      if (CNT_W'(p) < numInR[fireSlot]) sum = sum + opnd[p];
    end
    selTrue = (opnd[1] != '0);
    resData = (opR[fireSlot] == OP_ADD) ? sum : opnd[0];
    resWave = (opR[fireSlot] == OP_WAVEADV) ? baseWave[fireSlot] + WAVE_W'(1)
                                            : baseWave[fireSlot];
    if (opR[fireSlot] == OP_STEER)
      sendMask = selTrue ? {dstValR[fireSlot][1], 1'b0} : {1'b0, dstValR[fireSlot][0]};
    else
      sendMask = dstValR[fireSlot];
    fireNeedsTwo = &sendMask;
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        cfgd[s]      <= 1'b0;
        opR[s]       <= OP_ADD;
        numInR[s]    <= CNT_W'(1);
        dstValR[s]   <= '0;
        dst0SlotR[s] <= '0;
        dst0PortR[s] <= '0;
        dst1SlotR[s] <= '0;
        dst1PortR[s] <= '0;
        baseWave[s]  <= '0;
        for (int p = 0; p < MAX_IN; p++)
          for (int q = 0; q < QDEPTH; q++) qValid[s][p][q] <= 1'b0;
      end
    end else begin
      if (cfgValid) begin
        cfgd[cfgSlot]      <= 1'b1;
        opR[cfgSlot]       <= (cfgOp == 2'd1) ? OP_STEER :
                              (cfgOp == 2'd2) ? OP_WAVEADV : OP_ADD;
        numInR[cfgSlot]    <= (cfgNumIn == '0) ? CNT_W'(1) : cfgNumIn;
        dstValR[cfgSlot]   <= cfgDstValid;
        dst0SlotR[cfgSlot] <= cfgDst0Slot;
        dst0PortR[cfgSlot] <= cfgDst0Port;
        dst1SlotR[cfgSlot] <= cfgDst1Slot;
        dst1PortR[cfgSlot] <= cfgDst1Port;
        baseWave[cfgSlot]  <= '0;
        for (int p = 0; p < MAX_IN; p++)
          for (int q = 0; q < QDEPTH; q++) qValid[cfgSlot][p][q] <= 1'b0;
      end
      if (strobe.acceptTok) qValid[inSlot][inPort][inIdx] <= 1'b1;
      if (strobe.fire) begin
        for (int p = 0; p < MAX_IN; p++) qValid[fireSlot][p][fireIdx] <= 1'b0;
        baseWave[fireSlot] <= baseWave[fireSlot] + WAVE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.acceptTok) qData[inSlot][inPort][inIdx] <= inData;
  end

  // ---------------- output token register ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSlot  <= '0;
      outPort  <= '0;
      outWave  <= '0;
      outData  <= '0;
      holdSlot <= '0;
      holdPort <= '0;
    end else if (strobe.fire) begin
      outValid <= |sendMask;
      outSlot  <= sendMask[0] ? dst0SlotR[fireSlot] : dst1SlotR[fireSlot];
      outPort  <= sendMask[0] ? dst0PortR[fireSlot] : dst1PortR[fireSlot];
      outWave  <= resWave;
      outData  <= resData;
      holdSlot <= dst1SlotR[fireSlot];
      holdPort <= dst1PortR[fireSlot];
    end else if (strobe.sendSecond) begin
      outValid <= 1'b1;
      outSlot  <= holdSlot;
      outPort  <= holdPort;
    end else begin
      outValid <= 1'b0;
    end
  end

  // an accepted token occupies its entry on the next cycle
  p_accept_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptTok |=> qValid[$past(inSlot)][$past(inPort)][$past(inIdx)]);

  // every firing moves that slot's current wave forward by one
  p_base_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> (baseWave[$past(fireSlot)] == $past(baseWave[fireSlot]) + WAVE_W'(1)));

  // a two-destination firing produces a second token two edges later
  p_second_token_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && fireNeedsTwo) |-> ##2 outValid);

endmodule

// File: rtl/pe_fire_ctrl.sv
module pe_fire_ctrl
  import pe_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic                 inValid,
  input  logic                 tokFree,
  input  logic [NUM_SLOTS-1:0] readyVec,
  input  logic                 fireNeedsTwo,
  output logic                 inReady,
  output pe_strobe_t           strobe,
  output logic [SLOT_W-1:0]    fireSlot
);

  logic busy;
  logic anyReady;

  // fixed priority: lowest ready slot index
  always_comb begin
    anyReady = 1'b0;
    fireSlot = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (readyVec[s]) begin
        anyReady = 1'b1;
        fireSlot = SLOT_W'(s);
      end
    end
  end

  assign inReady           = tokFree && !cfgValid;
  assign strobe.acceptTok  = inValid && inReady;
  assign strobe.fire       = anyReady && !busy && !cfgValid;
  assign strobe.sendSecond = busy;

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= strobe.fire && fireNeedsTwo;
  end

  // the datapath must report the granted slot as matched
  p_fire_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> readyVec[fireSlot]);

endmodule

// File: rtl/pe_token_engine.sv
module pe_token_engine
  import pe_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int MAX_IN    = 3,
  parameter int QDEPTH    = 4,
  parameter int DATA_W    = 16,
  parameter int WAVE_W    = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int PORT_W   = $clog2(MAX_IN),
  localparam int CNT_W    = $clog2(MAX_IN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [1:0]        cfgOp,
  input  logic [CNT_W-1:0]  cfgNumIn,
  input  logic [1:0]        cfgDstValid,
  input  logic [SLOT_W-1:0] cfgDst0Slot,
  input  logic [PORT_W-1:0] cfgDst0Port,
  input  logic [SLOT_W-1:0] cfgDst1Slot,
  input  logic [PORT_W-1:0] cfgDst1Port,
  input  logic              inValid,
  output logic              inReady,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic [PORT_W-1:0] inPort,
  input  logic [WAVE_W-1:0] inWave,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [SLOT_W-1:0] outSlot,
  output logic [PORT_W-1:0] outPort,
  output logic [WAVE_W-1:0] outWave,
  output logic [DATA_W-1:0] outData
);

  pe_strobe_t           strobe;
  logic [SLOT_W-1:0]    fireSlot;
  logic                 tokFree;
  logic [NUM_SLOTS-1:0] readyVec;
  logic                 fireNeedsTwo;

  pe_fire_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .inValid(inValid),
    .tokFree(tokFree), .readyVec(readyVec), .fireNeedsTwo(fireNeedsTwo),
    .inReady(inReady), .strobe(strobe), .fireSlot(fireSlot)
  );

  pe_token_store #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_IN(MAX_IN), .QDEPTH(QDEPTH),
    .DATA_W(DATA_W), .WAVE_W(WAVE_W)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgSlot(cfgSlot), .cfgOp(cfgOp), .cfgNumIn(cfgNumIn),
    .cfgDstValid(cfgDstValid), .cfgDst0Slot(cfgDst0Slot), .cfgDst0Port(cfgDst0Port),
    .cfgDst1Slot(cfgDst1Slot), .cfgDst1Port(cfgDst1Port),
    .inSlot(inSlot), .inPort(inPort), .inWave(inWave), .inData(inData),
    .strobe(strobe), .fireSlot(fireSlot),
    .tokFree(tokFree), .readyVec(readyVec), .fireNeedsTwo(fireNeedsTwo),
    .outValid(outValid), .outSlot(outSlot), .outPort(outPort),
    .outWave(outWave), .outData(outData)
  );

endmodule

// File: tb/pe_token_engine_bench.sv
`timescale 1ns/100ps
module pe_token_engine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgValid = 1'b0;
  logic [2:0] cfgSlot = '0;
  logic [1:0] cfgOp = '0;
  logic [1:0] cfgNumIn = '0;
  logic [1:0] cfgDstValid = '0;
  logic [2:0] cfgDst0Slot = '0;
  logic [1:0] cfgDst0Port = '0;
  logic [2:0] cfgDst1Slot = '0;
  logic [1:0] cfgDst1Port = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [2:0] inSlot = '0;
  logic [1:0] inPort = '0;
  logic [7:0] inWave = '0;
  logic [15:0] inData = '0;
  logic       outValid;
  logic [2:0] outSlot;
  logic [1:0] outPort;
  logic [7:0] outWave;
  logic [15:0] outData;

  always #2 clk = ~clk;

  pe_token_engine u_pe_token_engine (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgSlot(cfgSlot), .cfgOp(cfgOp),
    .cfgNumIn(cfgNumIn), .cfgDstValid(cfgDstValid), .cfgDst0Slot(cfgDst0Slot),
    .cfgDst0Port(cfgDst0Port), .cfgDst1Slot(cfgDst1Slot), .cfgDst1Port(cfgDst1Port),
    .inValid(inValid), .inReady(inReady), .inSlot(inSlot), .inPort(inPort),
    .inWave(inWave), .inData(inData), .outValid(outValid), .outSlot(outSlot),
    .outPort(outPort), .outWave(outWave), .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastCyc = 0;
  int logCnt = 0;
  logic [2:0]  logSlot [32];
  logic [1:0]  logPort [32];
  logic [7:0]  logWave [32];
  logic [15:0] logData [32];
  int          logCyc  [32];

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (outValid && logCnt < 32) begin
      logSlot[logCnt] = outSlot;
      logPort[logCnt] = outPort;
      logWave[logCnt] = outWave;
      logData[logCnt] = outData;
      logCyc[logCnt]  = cyc;
      logCnt++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic cfg(int slot, int op, int nIn, int dv, int s0, int p0, int s1, int p1);
    @(negedge clk); #1;
    cfgValid = 1'b1; cfgSlot = 3'(slot); cfgOp = 2'(op); cfgNumIn = 2'(nIn);
    cfgDstValid = 2'(dv); cfgDst0Slot = 3'(s0); cfgDst0Port = 2'(p0);
    cfgDst1Slot = 3'(s1); cfgDst1Port = 2'(p1);
    @(posedge clk); #0.5;
    cfgValid = 1'b0;
  endtask

  task automatic send(int slot, int port, int wave, int data, logic expReady, string req);
    @(negedge clk); #1;
    inValid = 1'b1; inSlot = 3'(slot); inPort = 2'(port);
    inWave = 8'(wave); inData = 16'(data);
    #0.5;
    chk(req, "inReady", inReady, expReady);
    @(posedge clk); #0.5;
    lastCyc = cyc;
    inValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expTok(int i, int sl, int pt, int wv, int dt, string req);
    chk(req, "token present", i < logCnt, 1);
    if (i < logCnt) begin
      chk(req, "dest slot", logSlot[i], sl);
      chk(req, "dest port", logPort[i], pt);
      chk(req, "wave", logWave[i], wv);
      chk(req, "data", logData[i], dt);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    chk("R1", "outValid after reset", outValid, 0);
    send(0, 0, 0, 5, 1'b0, "R1");
  endtask

  // R4: add, timing; R3: partial operands do not fire
  task automatic t_add();
    int s;
    cfg(0, 0, 2, 1, 5, 1, 0, 0);
    s = logCnt;
    send(0, 0, 0, 10, 1'b1, "R2");
    idle(3);
    chk("R3", "no fire with one operand", logCnt - s, 0);
    send(0, 1, 0, 7, 1'b1, "R2");
    idle(3);
    chk("R4", "token count", logCnt - s, 1);
    expTok(s, 5, 1, 0, 17, "R4");
    chk("R4", "output cycle", logCyc[s], lastCyc + 2);
  endtask

  // R3: different waves never combined, waves in order
  task automatic t_waves();
    int s;
    s = logCnt;
    send(0, 0, 1, 3, 1'b1, "R3");
    send(0, 1, 2, 4, 1'b1, "R3");
    idle(3);
    chk("R3", "no fire on mismatched waves", logCnt - s, 0);
    send(0, 1, 1, 5, 1'b1, "R3");
    idle(3);
    chk("R3", "one firing for wave 1", logCnt - s, 1);
    expTok(s, 5, 1, 1, 8, "R3");
    send(0, 0, 2, 6, 1'b1, "R3");
    idle(3);
    expTok(s + 1, 5, 1, 2, 10, "R3");
  endtask

  // R9: backpressure and window slide
  task automatic t_backpressure();
    int s;
    s = logCnt;
    send(0, 0, 3, 1, 1'b1, "R9");
    send(0, 0, 3, 9, 1'b0, "R9");
    send(0, 0, 7, 9, 1'b0, "R9");
    send(0, 0, 2, 9, 1'b0, "R9");
    send(0, 0, 4, 2, 1'b1, "R9");
    send(0, 0, 5, 2, 1'b1, "R9");
    send(0, 0, 6, 2, 1'b1, "R9");
    send(0, 1, 3, 0, 1'b1, "R9");
    idle(3);
    chk("R9", "one firing", logCnt - s, 1);
    expTok(s, 5, 1, 3, 1, "R9");
    send(0, 0, 7, 4, 1'b1, "R9");
  endtask

  // R10: reconfiguration clears queues and wave
  task automatic t_reconfig();
    int s;
    cfg(0, 0, 2, 1, 5, 0, 0, 0);
    s = logCnt;
    send(0, 1, 0, 2, 1'b1, "R10");
    idle(3);
    chk("R10", "stale operand discarded", logCnt - s, 0);
    send(0, 0, 0, 20, 1'b1, "R10");
    idle(3);
    expTok(s, 5, 0, 0, 22, "R10");
  endtask

  // R5: steer
  task automatic t_steer();
    int s;
    cfg(1, 1, 2, 3, 2, 0, 3, 2);
    s = logCnt;
    send(1, 0, 0, 'h55, 1'b1, "R5");
    send(1, 1, 0, 0, 1'b1, "R5");
    idle(4);
    chk("R5", "single token false path", logCnt - s, 1);
    expTok(s, 2, 0, 0, 'h55, "R5");
    s = logCnt;
    send(1, 1, 1, 9, 1'b1, "R5");
    send(1, 0, 1, 'h66, 1'b1, "R5");
    idle(4);
    chk("R5", "single token true path", logCnt - s, 1);
    expTok(s, 3, 2, 1, 'h66, "R5");
  endtask

  // R6: wave advance; R2: port beyond count refused
  task automatic t_waveadv();
    int s;
    cfg(2, 2, 1, 1, 4, 0, 0, 0);
    send(2, 1, 0, 1, 1'b0, "R2");
    s = logCnt;
    send(2, 0, 0, 'h1234, 1'b1, "R6");
    idle(3);
    chk("R6", "token count", logCnt - s, 1);
    expTok(s, 4, 0, 1, 'h1234, "R6");
  endtask

  // R7: two destinations serialized
  task automatic t_twodest();
    int s;
    int c;
    cfg(3, 0, 3, 3, 6, 0, 7, 2);
    s = logCnt;
    send(3, 0, 0, 1, 1'b1, "R7");
    send(3, 1, 0, 2, 1'b1, "R7");
    send(3, 2, 0, 3, 1'b1, "R7");
    c = lastCyc;
    idle(4);
    chk("R7", "token count", logCnt - s, 2);
    expTok(s, 6, 0, 0, 6, "R7");
    expTok(s + 1, 7, 2, 0, 6, "R7");
    chk("R7", "first cycle", logCyc[s], c + 2);
    chk("R7", "second cycle", logCyc[s + 1], c + 3);
  endtask

  // R8: fixed priority after a stall
  task automatic t_priority();
    int s;
    int c;
    cfg(4, 0, 1, 1, 1, 1, 0, 0);
    cfg(6, 0, 1, 1, 0, 2, 0, 0);
    s = logCnt;
    send(3, 0, 1, 1, 1'b1, "R8");
    send(3, 1, 1, 1, 1'b1, "R8");
    send(3, 2, 1, 1, 1'b1, "R8");
    c = lastCyc;
    send(6, 0, 0, 'h66, 1'b1, "R8");
    send(4, 0, 0, 'h44, 1'b1, "R8");
    idle(5);
    chk("R8", "token count", logCnt - s, 4);
    expTok(s, 6, 0, 1, 3, "R8");
    expTok(s + 1, 7, 2, 1, 3, "R8");
    expTok(s + 2, 1, 1, 0, 'h44, "R8");
    expTok(s + 3, 0, 2, 0, 'h66, "R8");
    chk("R8", "lower slot cycle", logCyc[s + 2], c + 4);
    chk("R8", "higher slot cycle", logCyc[s + 3], c + 5);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    idle(1);
    t_reset();
    t_add();
    t_waves();
    t_backpressure();
    t_reconfig();
    t_steer();
    t_waveadv();
    t_twodest();
    t_priority();
    idle(2);
    summary();
  end

endmodule